// File: doc/BRIEF.md
# Vectored Interrupt Prioritizer

This block keeps track of up to 256 interrupt vectors for one processor. It holds three per-vector bit arrays: pending requests, vectors in service, and trigger mode (level or edge). It ranks vectors by number, with the higher number winning. Priority is compared in classes of 16 vectors, and the class of a vector is its upper four bits. A processor priority is formed from a programmable task priority and the highest vector in service. The block raises `irq_out` whenever the best pending request beats that processor priority.

The processor acknowledges with `ack_req`. One cycle later the block answers with one of three results: a real vector, which moves from pending to in service; the programmed spurious vector, when something is pending but blocked; or no vector at all. An end-of-interrupt strobe `eoi_req` retires the highest in-service vector. If that vector was level-triggered, the block announces it one cycle later on a broadcast pulse, unless broadcasts are suppressed.

The controller is disabled out of reset. Software enables it through the spurious-vector register port, which also sets the spurious vector and the broadcast-suppress flag.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset, all three bit arrays are empty, the task priority is 0, the spurious vector is 0xFF, the enable and suppress flags are clear, and `irq_out`, `ack_rsp` and `bcast_valid` are 0.
- R2: A request (`req_valid`) sets the pending bit of `req_vec`. It also sets that vector's trigger-mode bit when `req_level`=1 and clears it when `req_level`=0, so a later request can overwrite an earlier trigger mode.
- R3: The class of a vector is bits 7:4. A request is deliverable only when the class of the highest pending vector is strictly greater than the class of the processor priority. A request in the same class is blocked. A processor priority of 0 blocks nothing.
- R4: The processor priority equals the task priority when the task-priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that in-service class followed by four zero bits. An empty in-service array counts as class 0.
- R5: An acknowledge while a request is deliverable gives, one cycle later, `ack_rsp`=1, `ack_hit`=1, `ack_spur`=0 and `ack_vec` equal to the highest pending vector. In the same cycle that vector leaves the pending array and enters the in-service array.
- R6: An acknowledge while requests are pending but blocked gives `ack_rsp`=1, `ack_hit`=1, `ack_spur`=1 and `ack_vec` equal to the spurious vector. No array changes.
- R7: An acknowledge with nothing pending, or while the enable flag is clear, gives `ack_rsp`=1 and `ack_hit`=0.
- R8: An end-of-interrupt clears the highest set in-service bit. If that vector's trigger-mode bit is 1 and the suppress flag is 0, `bcast_valid` pulses for one cycle, one cycle later, with `bcast_vec` equal to that vector. Otherwise no pulse is issued.
- R9: `irq_out` is 1 only when the enable flag is set and a request is deliverable. The spurious-register write (`sv_we`) loads the vector, the enable flag and the suppress flag together.
- R10: `tpr_nib_we` stores `tpr_nib` into task-priority bits 7:4 and clears bits 3:0. `tpr_we` stores all 8 bits and wins when both ports write in the same cycle.
- R11: When `ack_req` and `eoi_req` arrive in the same cycle, the acknowledge is served and the end-of-interrupt is dropped.
- R12: An acknowledge works on the arrays as they were before the edge. A request arriving in the same cycle is recorded and can be delivered by a later acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Raise a request this cycle |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | Trigger mode of the request: 1 = level, 0 = edge |
| ack_req | input | 1 | Processor acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Full task-priority write |
| tpr_wdata | input | 8 | Full task-priority value |
| tpr_nib_we | input | 1 | Compact task-priority write |
| tpr_nib | input | 4 | Task-priority class for the compact write |
| sv_we | input | 1 | Spurious-register write |
| sv_wvec | input | 8 | Spurious vector to store |
| sv_wen | input | 1 | Enable flag to store |
| sv_wsupp | input | 1 | Broadcast-suppress flag to store |
| irq_out | output | 1 | A deliverable request exists |
| ack_rsp | output | 1 | Acknowledge answer cycle |
| ack_hit | output | 1 | The answer carries a vector |
| ack_spur | output | 1 | The carried vector is the spurious one |
| ack_vec | output | 8 | Returned vector, 0 when `ack_hit`=0 |
| bcast_valid | output | 1 | End-of-interrupt broadcast pulse |
| bcast_vec | output | 8 | Vector being broadcast, 0 otherwise |

## Verification
The ranking is exercised with requests in a higher class than the current in-service vector, in the same class, and in a lower class. These cases separate a strict class comparison from an inclusive one, and a class comparison from a full-byte comparison. Task-priority values with nonzero low bits (0x3F) and with a zero value show whether the processor priority is merged correctly and whether zero is treated as "block nothing". End-of-interrupt sequences mix level and edge vectors with the suppress flag both set and clear, and include a vector whose trigger mode was rewritten. Collisions of acknowledge with end-of-interrupt, with a new request, and of the two task-priority ports, fix the precedence rules.

// File: rtl/intp_pkg.sv
package intp_pkg;

    // Response phase, registered one cycle after the strobe that caused it
    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_ACK_VEC   = 3'd1,
        PH_ACK_SPUR  = 3'd2,
        PH_ACK_NONE  = 3'd3,
        PH_EOI_BCAST = 3'd4,
        PH_EOI_QUIET = 3'd5
    } phase_e;

endpackage

// File: rtl/intp_bitvec.sv
// One bit per vector with an indexed set and an indexed clear; set wins on a collision.
module intp_bitvec #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  q
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (set_en && (set_idx == IW'(i)))
                    q[i] <= 1'b1;
                else if (clr_en && (clr_idx == IW'(i)))
                    q[i] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/intp_top_find.sv
// Highest-set-bit search, split into priority classes of G bits.
module intp_top_find #(
    parameter int N = 256,
    parameter int G = 16
) (
    input  logic [N-1:0]         bits,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);

    localparam int NG = N / G;
    localparam int GW = $clog2(G);
    localparam int CW = $clog2(NG);

    logic [NG-1:0]    g_any;
    logic [NG*GW-1:0] loc_flat;
    logic [CW-1:0]    grp;

    generate
        for (genvar g = 0; g < NG; g++) begin : g_cls
            logic [GW-1:0] loc;
            assign g_any[g] = |bits[g*G +: G];
            always_comb begin
                loc = '0;
                for (int b = 0; b < G; b++)
                    if (bits[g*G + b]) loc = GW'(b);
            end
            assign loc_flat[g*GW +: GW] = loc;
        end
    endgenerate

    always_comb begin
        grp = '0;
        for (int k = 0; k < NG; k++)
            if (g_any[k]) grp = CW'(k);
    end

    assign any = |g_any;
    assign idx = {grp, loc_flat[grp*GW +: GW]};

endmodule

// File: rtl/intp_ppr.sv
// Processor priority merge and deliverability decision.
module intp_ppr #(
    parameter int VW = 8,
    parameter int CB = 4
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_any,
    input  logic [VW-1:0] isr_top,
    input  logic          irr_any,
    input  logic [VW-1:0] irr_top,
    output logic          deliverable
);

    logic [CB-1:0] isr_cls;
    logic [CB-1:0] tpr_cls;
    logic [VW-1:0] ppr;

    always_comb begin
        isr_cls = isr_any ? isr_top[VW-1 -: CB] : '0;
        tpr_cls = tpr[VW-1 -: CB];
        if (tpr_cls >= isr_cls)
            ppr = tpr;
        else
            ppr = {isr_cls, {(VW-CB){1'b0}}};
        deliverable = irr_any &&
                      ((ppr == '0) || (irr_top[VW-1 -: CB] > ppr[VW-1 -: CB]));
    end

endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
    import intp_pkg::*;
#(
    parameter int NVEC       = 256,
    parameter int CLASS_SIZE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [7:0] req_vec,
    input  logic       req_level,
    input  logic       ack_req,
    input  logic       eoi_req,
    input  logic       tpr_we,
    input  logic [7:0] tpr_wdata,
    input  logic       tpr_nib_we,
    input  logic [3:0] tpr_nib,
    input  logic       sv_we,
    input  logic [7:0] sv_wvec,
    input  logic       sv_wen,
    input  logic       sv_wsupp,
    output logic       irq_out,
    output logic       ack_rsp,
    output logic       ack_hit,
    output logic       ack_spur,
    output logic [7:0] ack_vec,
    output logic       bcast_valid,
    output logic [7:0] bcast_vec
);

    localparam int VW = $clog2(NVEC);
    localparam int GW = $clog2(CLASS_SIZE);
    localparam int CB = VW - GW;

    phase_e        state_q, state_n;
    logic [VW-1:0] rsp_vec_q, rsp_vec_n;

    logic [NVEC-1:0] irr_q, isr_q, tmr_q;
    logic            irr_any, isr_any;
    logic [VW-1:0]   irr_top, isr_top;
    logic            deliverable;

    logic [VW-1:0] tpr_q;
    logic [VW-1:0] sv_vec_q;
    logic          sv_en;
    logic          sv_supp;

    logic ack_take;
    logic ack_spur_take;
    logic eoi_take;

    // ---- request, in-service and trigger-mode arrays ----
    intp_bitvec #(.N(NVEC), .IW(VW)) u_irr (
        .clk(clk), .rst_n(rst_n),
        .set_en(req_valid), .set_idx(req_vec),
        .clr_en(ack_take),  .clr_idx(irr_top),
        .q(irr_q)
    );

    intp_bitvec #(.N(NVEC), .IW(VW)) u_isr (
        .clk(clk), .rst_n(rst_n),
        .set_en(ack_take), .set_idx(irr_top),
        .clr_en(eoi_take), .clr_idx(isr_top),
        .q(isr_q)
    );

    intp_bitvec #(.N(NVEC), .IW(VW)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .set_en(req_valid && req_level),  .set_idx(req_vec),
        .clr_en(req_valid && !req_level), .clr_idx(req_vec),
        .q(tmr_q)
    );

    intp_top_find #(.N(NVEC), .G(CLASS_SIZE)) u_irr_find (
        .bits(irr_q), .any(irr_any), .idx(irr_top)
    );

    intp_top_find #(.N(NVEC), .G(CLASS_SIZE)) u_isr_find (
        .bits(isr_q), .any(isr_any), .idx(isr_top)
    );

    intp_ppr #(.VW(VW), .CB(CB)) u_ppr (
        .tpr(tpr_q), .isr_any(isr_any), .isr_top(isr_top),
        .irr_any(irr_any), .irr_top(irr_top),
        .deliverable(deliverable)
    );

    // ---- programmable registers ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
        end else if (tpr_we) begin
            tpr_q <= tpr_wdata;
        end else if (tpr_nib_we) begin
            tpr_q <= {tpr_nib, {GW{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_vec_q <= '1;
            sv_en    <= 1'b0;
            sv_supp  <= 1'b0;
        end else if (sv_we) begin
            sv_vec_q <= sv_wvec;
            sv_en    <= sv_wen;
            sv_supp  <= sv_wsupp;
        end
    end

    // ---- strobe decode ----
    assign ack_take      = ack_req && sv_en && deliverable;
    assign ack_spur_take = ack_req && sv_en && irr_any && !deliverable;
    assign eoi_take      = eoi_req && !ack_req && isr_any;
    assign irq_out       = sv_en && deliverable;

    // ---- next phase ----
    always_comb begin
        state_n   = PH_IDLE;
        rsp_vec_n = '0;
        if (ack_req) begin
            if (ack_take) begin
                state_n   = PH_ACK_VEC;
                rsp_vec_n = irr_top;
            end else if (ack_spur_take) begin
                state_n   = PH_ACK_SPUR;
                rsp_vec_n = sv_vec_q;
            end else begin
                state_n   = PH_ACK_NONE;
            end
        end else if (eoi_req) begin
            if (eoi_take && tmr_q[isr_top] && !sv_supp) begin
                state_n   = PH_EOI_BCAST;
                rsp_vec_n = isr_top;
            end else begin
                state_n   = PH_EOI_QUIET;
            end
        end
    end

    // ---- phase register ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PH_IDLE;
            rsp_vec_q <= '0;
        end else begin
            state_q   <= state_n;
            rsp_vec_q <= rsp_vec_n;
        end
    end

    // ---- outputs decoded from phase ----
    always_comb begin
        ack_rsp     = 1'b0;
        ack_hit     = 1'b0;
        ack_spur    = 1'b0;
        ack_vec     = '0;
        bcast_valid = 1'b0;
        bcast_vec   = '0;
        unique case (state_q)
            PH_IDLE: ;
            PH_ACK_VEC: begin
                ack_rsp = 1'b1;
                ack_hit = 1'b1;
                ack_vec = rsp_vec_q;
            end
            PH_ACK_SPUR: begin
                ack_rsp  = 1'b1;
                ack_hit  = 1'b1;
                ack_spur = 1'b1;
                ack_vec  = rsp_vec_q;
            end
            PH_ACK_NONE: ack_rsp = 1'b1;
            PH_EOI_BCAST: begin
                bcast_valid = 1'b1;
                bcast_vec   = rsp_vec_q;
            end
            PH_EOI_QUIET: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/vec_prio_ctrl_chk.sv
module vec_prio_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ack_req,
    input logic eoi_req,
    input logic irq_out,
    input logic ack_rsp,
    input logic ack_hit,
    input logic ack_spur,
    input logic bcast_valid,
    input logic sv_en
);

    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_rsp); // R5
    AST_DELIVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && irq_out) |=> (ack_hit && !ack_spur)); // R5
    AST_SPUR_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_spur |-> ack_hit); // R6
    AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |-> ack_rsp); // R7
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !sv_en) |=> !ack_hit); // R7
    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !sv_en |-> !irq_out); // R9
    AST_BCAST_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> $past(eoi_req && !ack_req)); // R11
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_rsp, bcast_valid})); // R11

endmodule

bind vec_prio_ctrl vec_prio_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .eoi_req(eoi_req),
    .irq_out(irq_out), .ack_rsp(ack_rsp), .ack_hit(ack_hit),
    .ack_spur(ack_spur), .bcast_valid(bcast_valid), .sv_en(sv_en)
);

// File: tb/vec_prio_ctrl_test.sv
`timescale 1ns/1ps
module vec_prio_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vec = '0;
    logic       req_level = 1'b0;
    logic       ack_req = 1'b0;
    logic       eoi_req = 1'b0;
    logic       tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       tpr_nib_we = 1'b0;
    logic [3:0] tpr_nib = '0;
    logic       sv_we = 1'b0;
    logic [7:0] sv_wvec = '0;
    logic       sv_wen = 1'b0;
    logic       sv_wsupp = 1'b0;
    logic       irq_out, ack_rsp, ack_hit, ack_spur, bcast_valid;
    logic [7:0] ack_vec, bcast_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vec_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
        .ack_req(ack_req), .eoi_req(eoi_req),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .tpr_nib_we(tpr_nib_we), .tpr_nib(tpr_nib),
        .sv_we(sv_we), .sv_wvec(sv_wvec), .sv_wen(sv_wen), .sv_wsupp(sv_wsupp),
        .irq_out(irq_out), .ack_rsp(ack_rsp), .ack_hit(ack_hit),
        .ack_spur(ack_spur), .ack_vec(ack_vec),
        .bcast_valid(bcast_valid), .bcast_vec(bcast_vec)
    );

    localparam logic [2:0] OP_REQE = 3'd0, OP_REQL = 3'd1, OP_ACK = 3'd2,
                           OP_EOI  = 3'd3, OP_TPR  = 3'd4, OP_TPRN = 3'd5,
                           OP_SV   = 3'd6;

    // entry: op, arg, irq, hit, spur, bcast, vec, requirement number
    function automatic logic [34:0] ent(logic [2:0] op, logic [15:0] arg,
                                        logic irq, logic hit, logic spur,
                                        logic bc, logic [7:0] vec, logic [3:0] rq);
        return {op, arg, irq, hit, spur, bc, vec, rq};
    endfunction

    // OP_SV arg: [7:0] spurious vector, [8] enable, [12] suppress
    localparam int NT = 34;
    localparam logic [34:0] TBL [0:NT-1] = '{
        ent(OP_REQE, 16'h0041, 0, 0, 0, 0, 8'h00, 9),  // R9 disabled
        ent(OP_ACK,  16'h0000, 0, 0, 0, 0, 8'h00, 7),  // R7 disabled ack
        ent(OP_SV,   16'h01FF, 1, 0, 0, 0, 8'h00, 9),  // R9 enable
        ent(OP_REQL, 16'h0085, 1, 0, 0, 0, 8'h00, 2),  // R2
        ent(OP_ACK,  16'h0000, 0, 1, 0, 0, 8'h85, 5),  // R5 highest wins
        ent(OP_ACK,  16'h0000, 0, 1, 1, 0, 8'hFF, 6),  // R6 blocked
        ent(OP_REQE, 16'h0092, 1, 0, 0, 0, 8'h00, 3),  // R3 higher class
        ent(OP_ACK,  16'h0000, 0, 1, 0, 0, 8'h92, 4),  // R4
        ent(OP_EOI,  16'h0000, 0, 0, 0, 0, 8'h00, 8),  // R8 edge vector
        ent(OP_EOI,  16'h0000, 1, 0, 0, 1, 8'h85, 8),  // R8 level broadcast
        ent(OP_TPRN, 16'h0004, 0, 0, 0, 0, 8'h00, 10), // R10 compact write
        ent(OP_TPR,  16'h003F, 1, 0, 0, 0, 8'h00, 4),  // R4 low bits
        ent(OP_ACK,  16'h0000, 0, 1, 0, 0, 8'h41, 5),  // R5
        ent(OP_ACK,  16'h0000, 0, 0, 0, 0, 8'h00, 7),  // R7 empty
        ent(OP_SV,   16'h1107, 0, 0, 0, 0, 8'h00, 9),  // R9 suppress on
        ent(OP_REQL, 16'h0050, 1, 0, 0, 0, 8'h00, 4),  // R4 isr class merge
        ent(OP_ACK,  16'h0000, 0, 1, 0, 0, 8'h50, 5),  // R5
        ent(OP_EOI,  16'h0000, 0, 0, 0, 0, 8'h00, 8),  // R8 suppressed
        ent(OP_EOI,  16'h0000, 0, 0, 0, 0, 8'h00, 8),  // R8
        ent(OP_REQE, 16'h0030, 0, 0, 0, 0, 8'h00, 3),  // R3 same class blocked
        ent(OP_ACK,  16'h0000, 0, 1, 1, 0, 8'h07, 6),  // R6
        ent(OP_TPR,  16'h0000, 1, 0, 0, 0, 8'h00, 3),  // R3 zero blocks nothing
        ent(OP_ACK,  16'h0000, 0, 1, 0, 0, 8'h30, 5),  // R5
        ent(OP_SV,   16'h00FF, 0, 0, 0, 0, 8'h00, 9),  // R9 disable
        ent(OP_REQE, 16'h0010, 0, 0, 0, 0, 8'h00, 9),  // R9
        ent(OP_ACK,  16'h0000, 0, 0, 0, 0, 8'h00, 7),  // R7
        ent(OP_EOI,  16'h0000, 0, 0, 0, 0, 8'h00, 8),  // R8
        ent(OP_SV,   16'h01FF, 1, 0, 0, 0, 8'h00, 9),  // R9
        ent(OP_ACK,  16'h0000, 0, 1, 0, 0, 8'h10, 5),  // R5
        ent(OP_EOI,  16'h0000, 0, 0, 0, 0, 8'h00, 8),  // R8
        ent(OP_REQL, 16'h0060, 1, 0, 0, 0, 8'h00, 2),  // R2 level
        ent(OP_REQE, 16'h0060, 1, 0, 0, 0, 8'h00, 2),  // R2 rewritten to edge
        ent(OP_ACK,  16'h0000, 0, 1, 0, 0, 8'h60, 5),  // R5
        ent(OP_EOI,  16'h0000, 0, 0, 0, 0, 8'h00, 2)   // R2 no broadcast
    };

    task automatic chk(input int rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; ack_req = 1'b0; eoi_req = 1'b0;
        tpr_we = 1'b0; tpr_nib_we = 1'b0; sv_we = 1'b0;
    endtask

    task automatic ack_expect(input int rq, input logic hit, input logic spur,
                              input logic [7:0] vec);
        chk(rq, "ack_rsp", int'(ack_rsp), 1);
        chk(rq, "ack_hit", int'(ack_hit), int'(hit));
        chk(rq, "ack_spur", int'(ack_spur), int'(spur));
        chk(rq, "ack_vec", int'(ack_vec), int'(vec));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(1, "irq_out after reset", int'(irq_out), 0);
        chk(1, "ack_rsp after reset", int'(ack_rsp), 0);
        chk(1, "bcast_valid after reset", int'(bcast_valid), 0);

        for (int i = 0; i < NT; i++) begin
            logic [2:0]  op;
            logic [15:0] arg;
            logic        e_irq, e_hit, e_spur, e_bc;
            logic [7:0]  e_vec;
            logic [3:0]  rq;
            {op, arg, e_irq, e_hit, e_spur, e_bc, e_vec, rq} = TBL[i];
            case (op)
                OP_REQE: begin req_valid = 1'b1; req_vec = arg[7:0]; req_level = 1'b0; end
                OP_REQL: begin req_valid = 1'b1; req_vec = arg[7:0]; req_level = 1'b1; end
                OP_ACK:  ack_req = 1'b1;
                OP_EOI:  eoi_req = 1'b1;
                OP_TPR:  begin tpr_we = 1'b1; tpr_wdata = arg[7:0]; end
                OP_TPRN: begin tpr_nib_we = 1'b1; tpr_nib = arg[3:0]; end
                OP_SV:   begin sv_we = 1'b1; sv_wvec = arg[7:0]; sv_wen = arg[8]; sv_wsupp = arg[12]; end
                default: ;
            endcase
            step();
            chk(int'(rq), $sformatf("irq_out step %0d", i), int'(irq_out), int'(e_irq));
            if (op == OP_ACK) begin
                ack_expect(int'(rq), e_hit, e_spur, e_vec);
            end else if (op == OP_EOI) begin
                chk(int'(rq), $sformatf("bcast_valid step %0d", i), int'(bcast_valid), int'(e_bc));
                chk(int'(rq), $sformatf("bcast_vec step %0d", i), int'(bcast_vec), int'(e_vec));
            end else begin
                chk(int'(rq), $sformatf("ack_rsp idle step %0d", i), int'(ack_rsp), 0);
            end
        end

        // R11: acknowledge and end-of-interrupt together; the EOI is dropped
        req_valid = 1'b1; req_vec = 8'h70; req_level = 1'b0; step();
        ack_req = 1'b1; step();
        ack_expect(5, 1'b1, 1'b0, 8'h70);
        req_valid = 1'b1; req_vec = 8'hA0; req_level = 1'b1; step();
        chk(3, "irq_out class A over 7", int'(irq_out), 1);
        ack_req = 1'b1; eoi_req = 1'b1; step();
        ack_expect(11, 1'b1, 1'b0, 8'hA0);
        chk(11, "no broadcast on collided EOI", int'(bcast_valid), 0);
        eoi_req = 1'b1; step();
        chk(11, "EOI retires A0 (not dropped 70)", int'(bcast_valid), 1);
        chk(11, "bcast_vec", int'(bcast_vec), 8'hA0);
        eoi_req = 1'b1; step();
        chk(8, "edge 70 no broadcast", int'(bcast_valid), 0);
        chk(8, "irq_out after all retired", int'(irq_out), 0);

        // R12: request and acknowledge in the same cycle
        ack_req = 1'b1; req_valid = 1'b1; req_vec = 8'hC0; req_level = 1'b0; step();
        ack_expect(12, 1'b0, 1'b0, 8'h00);
        chk(12, "irq_out after recorded request", int'(irq_out), 1);

        // R10: both task-priority ports at once; full write wins
        tpr_we = 1'b1; tpr_wdata = 8'h00; tpr_nib_we = 1'b1; tpr_nib = 4'hF; step();
        chk(10, "full tpr write wins", int'(irq_out), 1);
        tpr_nib_we = 1'b1; tpr_nib = 4'hF; step();
        chk(10, "compact write class F blocks C0", int'(irq_out), 0);
        tpr_we = 1'b1; tpr_wdata = 8'h00; step();
        ack_req = 1'b1; step();
        ack_expect(12, 1'b1, 1'b0, 8'hC0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule